// File: doc/BRIEF.md
# Reloading Down-Counter Timer with Bus Access

This peripheral sits on an APB slave port and provides one 32-bit counter that counts downward. Software programs a reload value and starts the counter. Each time the counter is at zero and a count tick arrives, the counter takes the reload value again and sets a sticky interrupt flag. A level interrupt output follows that flag when interrupts are enabled.

The counter can tick in three ways. It can tick on every bus clock. It can tick on every bus clock while an external pin is high, which uses the pin as a gate. It can also tick once for each rising edge of the external pin, which uses the pin as a slow count clock. The pin passes through a synchronizer before the counter sees it. Software can overwrite the running count at any time, for example to restart a period from the reload value.

Top module: `apb_reload_timer`

## Requirements
- R1: After reset, every register reads 0 and `irq` is low.
- R2: The mode word at byte offset 0x000 keeps bits [3:0] and reads 0 in bits [31:4]. The reload word at 0x008 reads back all 32 bits. A write to the count word at 0x004 loads the counter, and the written value reads back.
- R3: With mode bit 0 (run) set and mode bits 1 and 2 clear, the count drops by one on every clock.
- R4: A tick that finds the count at zero loads the reload value and sets the pending flag, so one period lasts reload+1 ticks.
- R5: With mode bit 0 clear, the count does not change.
- R6: With mode bits 1 and 0 set and bit 2 clear, the count drops by one on each clock while the synchronized pin is high, and holds while the pin is low.
- R7: With mode bits 2 and 0 set, the count drops by exactly one for each rising edge of the pin. Mode bit 1 has no effect in this case.
- R8: Bit 0 of the word at 0x00C reads as the pending flag. Writing that bit as 1 clears the flag, and writing it as 0 leaves the flag unchanged.
- R9: `irq` is high when the pending flag is set and mode bit 3 is set. The flag still latches while bit 3 is clear.
- R10: If a clear write and a zero event fall in the same cycle, the flag ends up set.
- R11: Offsets other than the four aligned words read as 0, and writes to them change nothing.
- R12: A count write in the same cycle as a tick takes priority over the tick, and counting then continues from the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Bus and counter clock |
| presetn | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase strobe |
| pwrite | input | 1 | 1 for a write, 0 for a read |
| paddr | input | 12 | Byte address |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, decoded from paddr |
| ext_in | input | 1 | External gate or count-clock pin, asynchronous |
| irq | output | 1 | Level interrupt request |

## Verification
A wrong count shows up at the port the next time software reads the count word. In internal-tick mode, one bad decrement or reload leaves a read that is off by the error, and the error stays there for the rest of the run. A wrong pending flag shows up on `irq` in the cycle after the event, if interrupts are enabled, and otherwise on the next read at 0x00C. The bench therefore stops the counter before each read, so every count it reads is exact. Pin-driven modes are checked by exact tick counts taken after the synchronizer has settled, so a missed or doubled edge changes the count that is read back.

// File: rtl/rtm_pkg.sv
package rtm_pkg;
   // Word index inside the 16-byte window (paddr[3:2]).
   localparam logic [1:0] IDX_MODE   = 2'd0;
   localparam logic [1:0] IDX_COUNT  = 2'd1;
   localparam logic [1:0] IDX_RELOAD = 2'd2;
   localparam logic [1:0] IDX_FLAG   = 2'd3;

   localparam int MODE_W = 4;

   // Field order matches the bit positions software uses.
   typedef struct packed {
      logic irq_en;   // bit 3
      logic pin_clk;  // bit 2: pin edges are the tick
      logic pin_gate; // bit 1: pin level gates the tick
      logic run;      // bit 0
   } mode_t;
endpackage

// File: rtl/rtm_ext_sync.sv
module rtm_ext_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin,
   output logic level,
   output logic rise
);
   logic [STAGES-1:0] chain;
   logic              last;

   initial begin
      assert (STAGES >= 2) else $error("rtm_ext_sync: STAGES must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain <= '0;
         last  <= 1'b0;
      end else begin
         chain <= {chain[STAGES-2:0], pin};
         last  <= chain[STAGES-1];
      end
   end

   assign level = chain[STAGES-1];
   assign rise  = chain[STAGES-1] & ~last;
endmodule

// File: rtl/rtm_down_counter.sv
module rtm_down_counter #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   input  logic         tick,
   input  logic [W-1:0] reload_val,
   output logic [W-1:0] count,
   output logic         zero_evt
);
   logic at_zero;
   assign at_zero  = (count == '0);
   assign zero_evt = tick & ~load & at_zero;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       count <= '0;
      else if (load)    count <= load_val;
      else if (tick)    count <= at_zero ? reload_val : count - 1'b1;
   end

   assert_decr_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !load && count != '0) |=> count == $past(count) - 1'b1);
   assert_reload_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !load && count == '0) |=> count == $past(reload_val));
   assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !load) |=> $stable(count));
   assert_load_R12: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> count == $past(load_val));
endmodule

// File: rtl/rtm_irq_flag.sv
module rtm_irq_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set,
   input  logic clr,
   output logic pending
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   pending <= 1'b0;
      else if (set) pending <= 1'b1;
      else if (clr) pending <= 1'b0;
   end

   assert_set_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
      set |=> pending);
   assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !set) |=> !pending);
endmodule

// File: rtl/apb_reload_timer.sv
module apb_reload_timer
   import rtm_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int ADDR_W = 12,
   parameter int SYNC_STAGES = 2
) (
   input  logic              pclk,
   input  logic              presetn,
   input  logic              psel,
   input  logic              penable,
   input  logic              pwrite,
   input  logic [ADDR_W-1:0] paddr,
   input  logic [DATA_W-1:0] pwdata,
   output logic [DATA_W-1:0] prdata,
   input  logic              ext_in,
   output logic              irq
);
   localparam int PAD_W = DATA_W - MODE_W;

   initial begin
      assert (DATA_W > MODE_W) else $error("apb_reload_timer: DATA_W too small");
      assert (ADDR_W >= 4)     else $error("apb_reload_timer: ADDR_W too small");
   end

   mode_t             mode_q;
   logic [DATA_W-1:0] reload_q;
   logic [DATA_W-1:0] count;
   logic              zero_evt, pending, tick;
   logic              pin_lvl, pin_rise;
   logic              in_window, wr_acc;
   logic [1:0]        idx;

   assign in_window = (paddr[1:0] == 2'b00) && (paddr[ADDR_W-1:4] == '0);
   assign idx       = paddr[3:2];
   assign wr_acc    = psel & penable & pwrite & in_window;

   always_ff @(posedge pclk or negedge presetn) begin
      if (!presetn) begin
         mode_q   <= '0;
         reload_q <= '0;
      end else if (wr_acc) begin
         if (idx == IDX_MODE)   mode_q   <= mode_t'(pwdata[MODE_W-1:0]);
         if (idx == IDX_RELOAD) reload_q <= pwdata;
      end
   end

   rtm_ext_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(pclk), .rst_n(presetn), .pin(ext_in), .level(pin_lvl), .rise(pin_rise)
   );

   always_comb begin
      if (!mode_q.run)        tick = 1'b0;
      else if (mode_q.pin_clk) tick = pin_rise;
      else if (mode_q.pin_gate) tick = pin_lvl;
      else                    tick = 1'b1;
   end

   rtm_down_counter #(.W(DATA_W)) u_cnt (
      .clk(pclk), .rst_n(presetn),
      .load(wr_acc && idx == IDX_COUNT), .load_val(pwdata),
      .tick(tick), .reload_val(reload_q),
      .count(count), .zero_evt(zero_evt)
   );

   rtm_irq_flag u_flag (
      .clk(pclk), .rst_n(presetn),
      .set(zero_evt), .clr(wr_acc && idx == IDX_FLAG && pwdata[0]),
      .pending(pending)
   );

   assign irq = pending & mode_q.irq_en;

   always_comb begin
      prdata = '0;
      if (in_window) begin
         case (idx)
            IDX_MODE:   prdata = {{PAD_W{1'b0}}, mode_q};
            IDX_COUNT:  prdata = count;
            IDX_RELOAD: prdata = reload_q;
            default:    prdata = {{(DATA_W-1){1'b0}}, pending};
         endcase
      end
   end

   assert_irq_needs_flag_R9: assert property (@(posedge pclk) disable iff (!presetn)
      $rose(irq) |-> ($past(zero_evt) || $past(wr_acc && idx == IDX_MODE)));
endmodule

// File: tb/apb_reload_timer_tb.sv
module apb_reload_timer_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        psel = 0, penable = 0, pwrite = 0;
   logic [11:0] paddr = '0;
   logic [31:0] pwdata = '0;
   logic [31:0] prdata;
   logic        ext_in = 1'b0;
   logic        irq;

   always #5 clk = ~clk;

   apb_reload_timer u_dut (
      .pclk(clk), .presetn(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
      .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .ext_in(ext_in), .irq(irq)
   );

   int          total = 0, bad = 0;
   logic [31:0] exp_q[$];
   string       tag_q[$];
   logic        rd_strobe = 1'b0;
   logic [31:0] mon_e;
   string       mon_t;
   bit          finished = 0;

   // Monitor: pops the expected item when a read result is on the bus.
   always @(posedge rd_strobe) begin
      mon_e = exp_q.pop_front();
      mon_t = tag_q.pop_front();
      total++;
      if (prdata !== mon_e) begin
         bad++;
         $display("FAIL %s: actual %h expected %h", mon_t, prdata, mon_e);
      end
   end

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      psel = 1; pwrite = 1; paddr = a; pwdata = d; penable = 0;
      @(negedge clk);
      penable = 1;
      @(negedge clk);
      psel = 0; penable = 0; pwrite = 0;
   endtask

   // Driver: issues a read and pushes the expected value to the scoreboard.
   task automatic rd(input logic [11:0] a, input logic [31:0] e, input string tag);
      @(negedge clk);
      psel = 1; pwrite = 0; paddr = a; penable = 0;
      @(negedge clk);
      penable = 1;
      exp_q.push_back(e);
      tag_q.push_back(tag);
      #2 rd_strobe = 1;
      #1 rd_strobe = 0;
      @(negedge clk);
      psel = 0; penable = 0;
   endtask

   task automatic chk_irq(input logic e, input string tag);
      @(negedge clk);
      #1;
      total++;
      if (irq !== e) begin
         bad++;
         $display("FAIL %s: actual irq=%b expected %b", tag, irq, e);
      end
   endtask

   initial begin
      #2_000_000;
      if (!finished) begin
         total++; bad++;
         $display("FAIL watchdog: actual hung expected done");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      idle(3);
      rst_n = 1'b1;
      // R1 reset state
      rd(12'h000, 32'h0, "R1 mode");
      rd(12'h004, 32'h0, "R1 count");
      rd(12'h008, 32'h0, "R1 reload");
      rd(12'h00C, 32'h0, "R1 flag");
      chk_irq(1'b0, "R1 irq");
      // R2 register access
      wr(12'h008, 32'hDEADBEEF);
      rd(12'h008, 32'hDEADBEEF, "R2 reload");
      wr(12'h000, 32'hFFFF_FFF0);
      rd(12'h000, 32'h0, "R2 mode upper bits");
      wr(12'h004, 32'h0000_1234);
      rd(12'h004, 32'h0000_1234, "R2 count load");
      // R11 unmapped
      wr(12'h010, 32'hFFFF_FFFF);
      wr(12'h006, 32'hFFFF_FFFF);
      rd(12'h010, 32'h0, "R11 read 0x010");
      rd(12'h006, 32'h0, "R11 misaligned read");
      rd(12'h008, 32'hDEADBEEF, "R11 reload untouched");
      rd(12'h004, 32'h0000_1234, "R11 count untouched");
      rd(12'h000, 32'h0, "R11 mode untouched");
      // R3 internal ticking: enable-to-disable write gap is 3 cycles + idle
      wr(12'h004, 32'd100);
      wr(12'h000, 32'h1);
      wr(12'h000, 32'h0);
      rd(12'h004, 32'd97, "R3 three ticks");
      wr(12'h000, 32'h1);
      idle(5);
      wr(12'h000, 32'h0);
      rd(12'h004, 32'd89, "R3 eight ticks");
      // R5 hold while stopped
      idle(10);
      rd(12'h004, 32'd89, "R5 hold");
      // R12 count write while running
      wr(12'h000, 32'h1);
      wr(12'h004, 32'd50);
      wr(12'h000, 32'h0);
      rd(12'h004, 32'd47, "R12 load over tick");
      // R4 / R9 zero event with irq disabled
      wr(12'h008, 32'd5);
      wr(12'h004, 32'd2);
      wr(12'h000, 32'h1);
      wr(12'h000, 32'h0);
      rd(12'h004, 32'd5, "R4 reload at zero");
      rd(12'h00C, 32'h1, "R4 flag set");
      chk_irq(1'b0, "R9 masked");
      wr(12'h000, 32'h8);
      chk_irq(1'b1, "R9 unmasked");
      // R8 write 0 no effect, write 1 clears
      wr(12'h00C, 32'h0);
      rd(12'h00C, 32'h1, "R8 write zero ignored");
      wr(12'h00C, 32'h1);
      rd(12'h00C, 32'h0, "R8 cleared");
      chk_irq(1'b0, "R8 irq dropped");
      // R4 period of reload+1 ticks
      wr(12'h000, 32'h9);
      idle(3);
      wr(12'h000, 32'h8);
      rd(12'h004, 32'd5, "R4 six-tick period");
      rd(12'h00C, 32'h1, "R4 flag after period");
      chk_irq(1'b1, "R9 irq after period");
      wr(12'h00C, 32'h1);
      // R10 set beats clear in the same cycle
      wr(12'h008, 32'd100);
      wr(12'h004, 32'd2);
      wr(12'h000, 32'h1);
      wr(12'h00C, 32'h1);
      wr(12'h000, 32'h0);
      rd(12'h00C, 32'h1, "R10 set wins");
      rd(12'h004, 32'd97, "R10 count");
      wr(12'h00C, 32'h1);
      // R6 gate mode
      wr(12'h004, 32'd1000);
      wr(12'h000, 32'h3);
      idle(10);
      wr(12'h000, 32'h0);
      rd(12'h004, 32'd1000, "R6 gate low holds");
      wr(12'h000, 32'h3);
      idle(3);
      ext_in = 1'b1;
      idle(7);
      ext_in = 1'b0;
      idle(6);
      wr(12'h000, 32'h0);
      rd(12'h004, 32'd993, "R6 gate high seven cycles");
      // R7 pin edge mode
      wr(12'h004, 32'd500);
      wr(12'h000, 32'h5);
      for (int i = 0; i < 4; i++) begin
         ext_in = 1'b1; idle(3);
         ext_in = 1'b0; idle(3);
      end
      idle(5);
      wr(12'h000, 32'h0);
      rd(12'h004, 32'd496, "R7 four edges");
      wr(12'h000, 32'h7);
      for (int i = 0; i < 2; i++) begin
         ext_in = 1'b1; idle(4);
         ext_in = 1'b0; idle(4);
      end
      idle(5);
      wr(12'h000, 32'h0);
      rd(12'h004, 32'd494, "R7 gate bit ignored");
      idle(2);
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule